// File: doc/BRIEF.md
# Iterative Half-Adder Self-Timed Adder

This block adds two unsigned N-bit operands with nothing more than one row of half-adder cells. Every cell owns two 2:1 selectors. In the first step the selectors pass the operand bits into the cells. In every later step they pass the cell's own previous sum and the carry from the cell below. The row keeps repeating until the internal carry vector is entirely zero. At that point the sum register holds the result.

The block is modelled synchronously, with one pass of the row per clock. Its latency therefore depends on the data: it equals the longest carry chain that the operands produce. No lookahead logic is needed for this, and over random operands the average count grows roughly with log2(N).

A request pulse loads the operands. The block raises a completion flag and presents the sum, a sticky carry-out and the number of feedback passes it needed. All of these are held until the next request.

Top module: `hai_adder`

## Requirements
- R1: After synchronous reset `done_o`, `cout_o`, `sum_o` and `iter_o` are all 0.
- R2: When `done_o` is 1, `{cout_o, sum_o}` equals `a + b` as an (N+1)-bit value, where `a` and `b` are the operands accepted with the last request.
- R3: `iter_o` equals the number of feedback passes performed. Start with s = a XOR b and c = (a AND b) shifted left by one and truncated to N bits. Then, while c is nonzero, apply s' = s XOR c and c' = (s AND c) shifted left and truncated. `iter_o` is the number of times that step runs, so it is 0 when the first step leaves no internal carry.
- R4: `iter_o` never exceeds N-1.
- R5: If a request is accepted at clock edge E, `done_o` is first 1 after edge E+2+`iter_o`.
- R6: During the operand-selection step the completion flag stays low. `done_o` is 0 after edges E and E+1 of an accepted request.
- R7: `req_i` is accepted only while no addition is in progress. A request raised while busy does not change the result of the addition in progress.
- R8: Once `done_o` is 1, the values of `sum_o`, `cout_o`, `iter_o` and `done_o` hold until the next accepted request. After that request's edge, `done_o` is 0.
- R9: The carry out of the most significant cell is not fed back. It is OR-accumulated into `cout_o`, so a carry that leaves the top bit in any pass appears on `cout_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start request, sampled on the rising edge |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| sum_o | output | N | Low N bits of the result |
| cout_o | output | 1 | Sticky carry out of the top bit |
| done_o | output | 1 | Completion flag, held until the next request |
| iter_o | output | $clog2(N) | Feedback passes used by the last addition |

## Verification
Several properties are checked on every cycle by the assertions:
- the arithmetic invariant that the registered sum, the shifted registered carries and the sticky carry-out always add up to the latched operands' total;
- the bound on the pass counter;
- that a busy request never restarts the load phase;
- that a raised completion implies zero carries;
- that the outputs hold in the done state.

Only the bench scenarios can show the data-dependent latency against the predicted pass count, and that this count matches an independently computed recursion. Those scenarios also cover the all-ones-plus-one worst case and the top-bit-only carry case, and show that a request during busy leaves the original result intact.

// File: rtl/hai_pkg.sv
package hai_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_ITER = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } ha_out_t;

    function automatic ha_out_t half_add(input logic x, input logic y);
        ha_out_t r;
        r.sum   = x ^ y;
        r.carry = x & y;
        return r;
    endfunction

endpackage

// File: rtl/hai_cell.sv
module hai_cell
    import hai_pkg::*;
(
    input  logic    sel_i,
    input  logic    op_a_i,
    input  logic    op_b_i,
    input  logic    fb_sum_i,
    input  logic    fb_cin_i,
    output ha_out_t res_o
);
    logic x_in;
    logic y_in;

    always_comb begin
        x_in  = sel_i ? fb_sum_i : op_a_i;
        y_in  = sel_i ? fb_cin_i : op_b_i;
        res_o = half_add(x_in, y_in);
    end
endmodule

// File: rtl/hai_row.sv
module hai_row
    import hai_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         sel_i,
    input  logic [N-1:0] op_a_i,
    input  logic [N-1:0] op_b_i,
    input  logic [N-1:0] fb_sum_i,
    input  logic [N-2:0] fb_carry_i,
    output logic [N-1:0] nsum_o,
    output logic [N-1:0] ncarry_o
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic    cin;
        ha_out_t res;

        if (i == 0) begin : g_lsb
            assign cin = 1'b0;
        end else begin : g_upper
            assign cin = fb_carry_i[i-1];
        end

        hai_cell u_cell (
            .sel_i    (sel_i),
            .op_a_i   (op_a_i[i]),
            .op_b_i   (op_b_i[i]),
            .fb_sum_i (fb_sum_i[i]),
            .fb_cin_i (cin),
            .res_o    (res)
        );

        assign nsum_o[i]   = res.sum;
        assign ncarry_o[i] = res.carry;
    end
endmodule

// File: rtl/hai_ctrl.sv
module hai_ctrl
    import hai_pkg::*;
#(
    parameter int N  = 32,
    parameter int CW = $clog2(N)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          req_i,
    input  logic          carries_zero_i,
    output logic          accept_o,
    output logic          sel_o,
    output logic          row_wr_o,
    output logic          done_o,
    output phase_e        phase_o,
    output logic [CW-1:0] iter_o
);
    phase_e        phase_q;
    logic [CW-1:0] count_q;
    logic          term;

    always_comb begin
        accept_o = req_i && ((phase_q == PH_IDLE) || (phase_q == PH_DONE));
        sel_o    = (phase_q == PH_ITER);
        term     = sel_o && carries_zero_i;
        row_wr_o = (phase_q == PH_LOAD) || (sel_o && !carries_zero_i);
        done_o   = (phase_q == PH_DONE);
        phase_o  = phase_q;
        iter_o   = count_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            count_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_DONE: begin
                    if (accept_o) begin
                        phase_q <= PH_LOAD;
                        count_q <= '0;
                    end
                end
                PH_LOAD: phase_q <= PH_ITER;
                PH_ITER: begin
                    if (term) begin
                        phase_q <= PH_DONE;
                    end else begin
                        count_q <= count_q + CW'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R4: pass counter bounded by N-1
    p_iter_bound_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        count_q <= CW'(N - 1));

    // R6: completion only follows a cycle with the feedback select active
    p_done_after_sel_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(done_o) |-> $past(sel_o));

    // R7: a busy phase never restarts the operand load
    p_busy_no_restart_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_LOAD || phase_q == PH_ITER) |=> (phase_q != PH_LOAD));
endmodule

// File: rtl/hai_adder.sv
module hai_adder
    import hai_pkg::*;
#(
    parameter int N  = 32,
    localparam int CW = $clog2(N)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          req_i,
    input  logic [N-1:0]  a_i,
    input  logic [N-1:0]  b_i,
    output logic [N-1:0]  sum_o,
    output logic          cout_o,
    output logic          done_o,
    output logic [CW-1:0] iter_o
);
    logic [N-1:0] opa_q;
    logic [N-1:0] opb_q;
    logic [N-1:0] sum_q;
    logic [N-2:0] carry_q;
    logic         cout_q;

    logic [N-1:0] nsum;
    logic [N-1:0] ncarry;
    logic         accept;
    logic         sel;
    logic         row_wr;
    logic         carries_zero;
    phase_e       phase;

    assign carries_zero = (carry_q == '0);

    hai_ctrl #(.N(N), .CW(CW)) u_ctrl (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .req_i          (req_i),
        .carries_zero_i (carries_zero),
        .accept_o       (accept),
        .sel_o          (sel),
        .row_wr_o       (row_wr),
        .done_o         (done_o),
        .phase_o        (phase),
        .iter_o         (iter_o)
    );

    hai_row #(.N(N)) u_row (
        .sel_i      (sel),
        .op_a_i     (opa_q),
        .op_b_i     (opb_q),
        .fb_sum_i   (sum_q),
        .fb_carry_i (carry_q),
        .nsum_o     (nsum),
        .ncarry_o   (ncarry)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            opa_q   <= '0;
            opb_q   <= '0;
            sum_q   <= '0;
            carry_q <= '0;
            cout_q  <= 1'b0;
        end else if (accept) begin
            opa_q   <= a_i;
            opb_q   <= b_i;
            carry_q <= '0;
            cout_q  <= 1'b0;
        end else if (row_wr) begin
            sum_q   <= nsum;
            carry_q <= ncarry[N-2:0];
            cout_q  <= cout_q | ncarry[N-1];
        end
    end

    assign sum_o  = sum_q;
    assign cout_o = cout_q;

    // R2: registered sum, shifted carries and sticky carry always total a+b
    p_sum_invariant_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase == PH_ITER || phase == PH_DONE) |->
        (({1'b0, opa_q} + {1'b0, opb_q}) ==
         ({cout_q, sum_q} + {1'b0, carry_q, 1'b0})));

    // R3: completion is reported only with every internal carry at zero
    p_done_no_carry_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (carry_q == '0));

    // R8: results hold in the done state until a new request
    p_done_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !req_i) |=>
        (done_o && $stable(sum_o) && $stable(cout_o) && $stable(iter_o)));

    // R9: the top-bit carry is sticky during an addition
    p_cout_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (cout_q && !accept) |=> cout_q);
endmodule

// File: tb/hai_adder_tb.sv
`timescale 1ns/1ps
module hai_adder_tb_top;
    localparam int N  = 32;
    localparam int CW = $clog2(N);
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          req;
    logic [N-1:0]  a;
    logic [N-1:0]  b;
    logic [N-1:0]  sum;
    logic          cout;
    logic          done;
    logic [CW-1:0] iters;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    hai_adder #(.N(N)) dut_i (
        .clk_i  (clk),
        .rst_i  (rst),
        .req_i  (req),
        .a_i    (a),
        .b_i    (b),
        .sum_o  (sum),
        .cout_o (cout),
        .done_o (done),
        .iter_o (iters)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    function automatic logic [N:0] exp_total(input logic [N-1:0] x, input logic [N-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    function automatic int exp_passes(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [N-1:0] s, c, t;
        int k;
        s = x ^ y;
        c = (x & y) << 1;
        k = 0;
        while (c != '0) begin
            t = s;
            s = s ^ c;
            c = (t & c) << 1;
            k++;
        end
        return k;
    endfunction

    task automatic check(input bit ok, input string req_tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req_tag, act, expv);
        end
    endtask

    task automatic run_op(input logic [N-1:0] x, input logic [N-1:0] y, input bit poke_busy);
        int lat;
        int k;
        logic [N:0] tot;
        tot = exp_total(x, y);
        k   = exp_passes(x, y);
        @(negedge clk);
        req = 1'b1; a = x; b = y;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R8 done cleared by request", done, 0);
        if (poke_busy) begin
            req = 1'b1; a = ~x; b = x;
        end else begin
            req = 1'b0;
        end
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        req = 1'b0;
        check(done == 1'b0, "R6 no completion in select phase", done, 0);
        if (poke_busy) begin
            req = 1'b1; a = '1; b = '1;
        end
        while (!done && lat < N + 8) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            req = 1'b0;
        end
        check({cout, sum} == tot, poke_busy ? "R7 busy request ignored" : "R2 sum",
              longint'({cout, sum}), longint'(tot));
        check(int'(iters) == k, "R3 pass count", iters, k);
        check(int'(iters) <= N - 1, "R4 pass bound", iters, N - 1);
        check(lat == 2 + k, "R5 latency", lat, 2 + k);
    endtask

    task automatic check_hold(input int wait_cycles);
        logic [N-1:0]  s0;
        logic          c0;
        logic [CW-1:0] i0;
        s0 = sum; c0 = cout; i0 = iters;
        repeat (wait_cycles) @(negedge clk);
        check(done && sum == s0 && cout == c0 && iters == i0, "R8 outputs held",
              longint'({done, cout, sum}), longint'({1'b1, c0, s0}));
    endtask

    initial begin
        logic [N-1:0] ra, rb;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; req = 1'b0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !cout && sum == '0 && iters == '0, "R1 reset state",
              longint'({done, cout, sum}), 0);

        run_op('0, '0, 1'b0);
        run_op('1, {{(N-1){1'b0}}, 1'b1}, 1'b0);
        check(cout == 1'b1 && int'(iters) == N - 1, "R4 worst chain reaches N-1", iters, N - 1);
        run_op('1, '1, 1'b0);
        run_op({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, 1'b0);
        check(cout == 1'b1 && sum == '0 && iters == '0, "R9 top carry not fed back",
              longint'({cout, sum}), longint'({1'b1, {N{1'b0}}}));
        run_op({(N/2){2'b01}}, {(N/2){2'b10}}, 1'b0);
        check(iters == '0 && cout == 1'b0, "R3 no carries gives zero passes", iters, 0);
        run_op(32'h0000_ffff, 32'h0000_0001, 1'b0);
        check_hold(5);
        run_op(32'h1234_5678, 32'h0fed_cba9, 1'b1);
        check_hold(3);

        for (int i = 0; i < 60; i++) begin
            ra = $urandom();
            rb = $urandom();
            if (i % 7 == 3) rb = ~ra + 1;
            run_op(ra, rb, (i % 5) == 2);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule